// File: doc/BRIEF.md
# Processor Power Mode Controller

This block sequences a processor core between full power and three low-power states: doze, nap and sleep. Software writes a configuration word that carries three mode-select bits and a clock-gating enable. The controller then drives one clock-enable line for each functional unit. It switches bus snooping on and off, and it runs a request/acknowledge coherency handshake with the system before it enters nap or sleep. Cycle-by-cycle dynamic gating can be turned on for full power. In that case a unit is clocked only in the cycles when the dispatch logic reports that it needs the unit.

Three events bring the core back to full power: an external asynchronous interrupt (passed through a two-flop synchronizer), a decrementer interrupt, and hard reset. Each low-power state has its own set of live units and its own set of accepted wake sources. In doze, a snoop hit wakes the data cache only for a copy-back, and the controller then returns to doze without going through full power.

The controller has seven states:
- FULL (0)
- DOZE (1)
- DOZE_CB (2), the copy-back service state
- NAP_WAIT (3) and SLEEP_WAIT (4), the handshake states
- NAP (5)
- SLEEP (6)

The transitions are:
- enter: FULL to DOZE, NAP_WAIT or SLEEP_WAIT
- grant: NAP_WAIT to NAP, SLEEP_WAIT to SLEEP
- abort: a wait state back to FULL
- snoop: DOZE to DOZE_CB
- resume: DOZE_CB to DOZE
- wake: DOZE, NAP or SLEEP to FULL

Top module: `power_mode_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it is released, the state is FULL (0), every unit clock enable is 1, snoop_en is 1, coh_req is 0, wake_valid is 1 and wake_cause is 3 (reset). Dynamic gating starts disabled. In the next cycle wake_valid is 0.
- R2: The gating enable is captured from cfg_dyn_gate on every cfg_wr, in any state. In FULL and in both wait states, unit_clk_en is all ones when gating is off. When gating is on it equals unit_need OR'd with the decrementer bit (unit 0), and it follows unit_need in the same cycle.
- R3: cfg_mode bit 0 selects doze, bit 1 selects nap and bit 2 selects sleep. A cfg_wr in FULL with exactly one bit set moves to DOZE, NAP_WAIT or SLEEP_WAIT at the next edge. Any other pattern (zero bits, or more than one) leaves the controller in FULL.
- R4: A cfg_wr received in any low-power state is ignored. The controller never moves from one low-power state directly to another.
- R5: In DOZE only the decrementer unit (unit 0) is clocked and snoop_en stays 1.
- R6: In DOZE a snoop_hit moves to DOZE_CB, where units 0 and 1 (decrementer and data cache) are clocked. DOZE_CB stays put until copyback_done, then returns to DOZE. It never passes through FULL.
- R7: In NAP_WAIT and SLEEP_WAIT, coh_req is 1 and the units are clocked as in FULL. When coh_ack is seen, the controller moves to NAP or SLEEP at the next edge.
- R8: A synchronized external interrupt or a decrementer interrupt during NAP_WAIT or SLEEP_WAIT returns the controller to FULL without a wake pulse.
- R9: In NAP only unit 0 is clocked, snoop_en is 0 and coh_req is 0. A decrementer or synchronized external interrupt wakes the controller to FULL.
- R10: In SLEEP no unit is clocked and snoop_en is 0. The decrementer interrupt is ignored, and only the synchronized external interrupt wakes the controller.
- R11: The external interrupt takes effect at the third rising edge after it is applied, because of the two synchronizer flops.
- R12: A wake to FULL raises wake_valid for exactly one cycle, and that cycle is the first one in FULL. wake_cause is 1 for external and 2 for decrementer. External wins when both are present at the same edge. wake_cause is 0 whenever wake_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low hard reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_mode | input | 3 | Mode request bits: [0] doze, [1] nap, [2] sleep |
| cfg_dyn_gate | input | 1 | Dynamic clock-gating enable, captured on cfg_wr |
| unit_need | input | NUM_UNITS | Per-unit demand from instruction dispatch |
| ext_irq_async | input | 1 | External asynchronous interrupt |
| dec_irq | input | 1 | Decrementer interrupt |
| snoop_hit | input | 1 | Snoop hit on a cached line |
| copyback_done | input | 1 | Copy-back to memory finished |
| coh_ack | input | 1 | System acknowledge of coherency |
| unit_clk_en | output | NUM_UNITS | Clock enable per functional unit |
| snoop_en | output | 1 | Bus snooping enabled |
| coh_req | output | 1 | Coherency handshake request |
| wake_valid | output | 1 | One-cycle wake pulse |
| wake_cause | output | 2 | 0 none, 1 external, 2 decrementer, 3 reset |
| power_state | output | 3 | Current state code |

## Verification
All eight mode-bit patterns are written from FULL. This separates the three legal single-bit requests from the empty and multi-bit patterns that must be ignored. All 32 demand vectors are applied with gating off and with gating on, which tells pass-through apart from forced enables. Each low-power state is then woken with every source it accepts and offered the one it must ignore. The external path is sampled at the second and third edges to pin down the synchronizer delay. Simultaneous interrupt sources and aborts during the handshake show whether priority is applied and whether a wake pulse is raised.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    typedef enum logic [2:0] {
        PS_FULL       = 3'd0,
        PS_DOZE       = 3'd1,
        PS_DOZE_CB    = 3'd2,
        PS_NAP_WAIT   = 3'd3,
        PS_SLEEP_WAIT = 3'd4,
        PS_NAP        = 3'd5,
        PS_SLEEP      = 3'd6
    } pstate_e;

    typedef enum logic [1:0] {
        WK_NONE = 2'd0,
        WK_EXT  = 2'd1,
        WK_DEC  = 2'd2,
        WK_RST  = 2'd3
    } wake_e;

    localparam int MODE_W     = 3;
    localparam int MODE_DOZE  = 0;
    localparam int MODE_NAP   = 1;
    localparam int MODE_SLEEP = 2;

endpackage

// File: rtl/pmc_sync.sv
module pmc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[s] <= 1'b0;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/pmc_req_decode.sv
module pmc_req_decode
    import pmc_pkg::*;
(
    input  logic              cfg_wr,
    input  logic [MODE_W-1:0] cfg_mode,
    output logic              req_valid,
    output pstate_e           req_target
);
    logic single_bit;

    always_comb begin
        single_bit = (cfg_mode != '0) && ((cfg_mode & (cfg_mode - 1'b1)) == '0);
        req_valid  = cfg_wr && single_bit;
        req_target = PS_FULL;
        if (cfg_mode[MODE_DOZE])  req_target = PS_DOZE;
        if (cfg_mode[MODE_NAP])   req_target = PS_NAP_WAIT;
        if (cfg_mode[MODE_SLEEP]) req_target = PS_SLEEP_WAIT;
    end
endmodule

// File: rtl/pmc_clk_en.sv
module pmc_clk_en
    import pmc_pkg::*;
#(
    parameter int NUM_UNITS   = 5,
    parameter int DEC_UNIT    = 0,
    parameter int DCACHE_UNIT = 1
) (
    input  pstate_e              state,
    input  logic                 dyn_en,
    input  logic [NUM_UNITS-1:0] unit_need,
    output logic [NUM_UNITS-1:0] clk_en,
    output logic                 snoop_en,
    output logic                 coh_req
);
    generate
        for (genvar i = 0; i < NUM_UNITS; i++) begin : g_unit
            localparam bit IS_DEC = (i == DEC_UNIT);
            localparam bit IS_DC  = (i == DCACHE_UNIT);
            logic en;

            always_comb begin
                unique case (state)
                    PS_FULL, PS_NAP_WAIT, PS_SLEEP_WAIT:
                        en = IS_DEC ? 1'b1 : (dyn_en ? unit_need[i] : 1'b1);
                    PS_DOZE, PS_NAP:
                        en = IS_DEC;
                    PS_DOZE_CB:
                        en = IS_DEC || IS_DC;
                    PS_SLEEP:
                        en = 1'b0;
                    default:
                        en = 1'b0;
                endcase
            end

            assign clk_en[i] = en;
        end
    endgenerate

    always_comb begin
        snoop_en = !((state == PS_NAP) || (state == PS_SLEEP));
        coh_req  = (state == PS_NAP_WAIT) || (state == PS_SLEEP_WAIT);
    end
endmodule

// File: rtl/power_mode_ctrl.sv
module power_mode_ctrl
    import pmc_pkg::*;
#(
    parameter int NUM_UNITS   = 5,
    parameter int DEC_UNIT    = 0,
    parameter int DCACHE_UNIT = 1,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_wr,
    input  logic [2:0]           cfg_mode,
    input  logic                 cfg_dyn_gate,
    input  logic [NUM_UNITS-1:0] unit_need,
    input  logic                 ext_irq_async,
    input  logic                 dec_irq,
    input  logic                 snoop_hit,
    input  logic                 copyback_done,
    input  logic                 coh_ack,
    output logic [NUM_UNITS-1:0] unit_clk_en,
    output logic                 snoop_en,
    output logic                 coh_req,
    output logic                 wake_valid,
    output logic [1:0]           wake_cause,
    output logic [2:0]           power_state
);
    pstate_e state_q, state_d;
    wake_e   wk_d, wake_cause_q;
    logic    wake_valid_q;
    logic    dyn_en_q;
    logic    irq_s;
    logic    req_valid;
    pstate_e req_target;

    pmc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (ext_irq_async),
        .q_sync  (irq_s)
    );

    pmc_req_decode u_dec (
        .cfg_wr     (cfg_wr),
        .cfg_mode   (cfg_mode),
        .req_valid  (req_valid),
        .req_target (req_target)
    );

    pmc_clk_en #(
        .NUM_UNITS   (NUM_UNITS),
        .DEC_UNIT    (DEC_UNIT),
        .DCACHE_UNIT (DCACHE_UNIT)
    ) u_clk_en (
        .state     (state_q),
        .dyn_en    (dyn_en_q),
        .unit_need (unit_need),
        .clk_en    (unit_clk_en),
        .snoop_en  (snoop_en),
        .coh_req   (coh_req)
    );

    // Transition logic
    always_comb begin
        state_d = state_q;
        wk_d    = WK_NONE;
        unique case (state_q)
            PS_FULL: begin
                if (req_valid) state_d = req_target;
            end
            PS_DOZE: begin
                if (irq_s) begin
                    state_d = PS_FULL;
                    wk_d    = WK_EXT;
                end else if (dec_irq) begin
                    state_d = PS_FULL;
                    wk_d    = WK_DEC;
                end else if (snoop_hit) begin
                    state_d = PS_DOZE_CB;
                end
            end
            PS_DOZE_CB: begin
                if (copyback_done) state_d = PS_DOZE;
            end
            PS_NAP_WAIT, PS_SLEEP_WAIT: begin
                if (irq_s || dec_irq)
                    state_d = PS_FULL;
                else if (coh_ack)
                    state_d = (state_q == PS_NAP_WAIT) ? PS_NAP : PS_SLEEP;
            end
            PS_NAP: begin
                if (irq_s) begin
                    state_d = PS_FULL;
                    wk_d    = WK_EXT;
                end else if (dec_irq) begin
                    state_d = PS_FULL;
                    wk_d    = WK_DEC;
                end
            end
            PS_SLEEP: begin
                if (irq_s) begin
                    state_d = PS_FULL;
                    wk_d    = WK_EXT;
                end
            end
            default: state_d = PS_FULL;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PS_FULL;
        end else begin
            state_q <= state_d;
        end
    end

    // Registered outputs and configuration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wake_valid_q <= 1'b1;
            wake_cause_q <= WK_RST;
            dyn_en_q     <= 1'b0;
        end else begin
            wake_valid_q <= (wk_d != WK_NONE);
            wake_cause_q <= wk_d;
            if (cfg_wr) dyn_en_q <= cfg_dyn_gate;
        end
    end

    assign wake_valid  = wake_valid_q;
    assign wake_cause  = wake_cause_q;
    assign power_state = state_q;

    AST_BAD_REQ_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_FULL && !(cfg_wr && $onehot(cfg_mode))) |=> state_q == PS_FULL); // R3

    AST_NAP_NO_HOP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_NAP) |=> (state_q == PS_NAP || state_q == PS_FULL)); // R4

    AST_CB_TO_DOZE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_DOZE_CB) |=> (state_q == PS_DOZE_CB || state_q == PS_DOZE)); // R6

    AST_GRANT_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_NAP && $past(state_q) != PS_NAP) |-> $past(coh_ack)); // R7

    AST_SNOOP_OFF_DEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_NAP || state_q == PS_SLEEP) |-> !snoop_en); // R9

    AST_SLEEP_ALL_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_SLEEP) |-> unit_clk_en == '0); // R10

    AST_SLEEP_DEC_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_SLEEP && !irq_s) |=> state_q == PS_SLEEP); // R10

    AST_WAKE_IN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        wake_valid |-> power_state == 3'd0); // R12

    AST_WAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_valid |=> !wake_valid); // R12

endmodule

// File: tb/power_mode_ctrl_tb.sv
module power_mode_ctrl_tb;
    localparam int NU = 5;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          cfg_wr = 1'b0;
    logic [2:0]    cfg_mode = '0;
    logic          cfg_dyn_gate = 1'b0;
    logic [NU-1:0] unit_need = '0;
    logic          ext_irq_async = 1'b0;
    logic          dec_irq = 1'b0;
    logic          snoop_hit = 1'b0;
    logic          copyback_done = 1'b0;
    logic          coh_ack = 1'b0;
    logic [NU-1:0] unit_clk_en;
    logic          snoop_en, coh_req, wake_valid;
    logic [1:0]    wake_cause;
    logic [2:0]    power_state;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    power_mode_ctrl #(.NUM_UNITS(NU)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_mode(cfg_mode),
        .cfg_dyn_gate(cfg_dyn_gate), .unit_need(unit_need),
        .ext_irq_async(ext_irq_async), .dec_irq(dec_irq), .snoop_hit(snoop_hit),
        .copyback_done(copyback_done), .coh_ack(coh_ack),
        .unit_clk_en(unit_clk_en), .snoop_en(snoop_en), .coh_req(coh_req),
        .wake_valid(wake_valid), .wake_cause(wake_cause), .power_state(power_state)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic wr_mode(input logic [2:0] m);
        cfg_wr = 1'b1; cfg_mode = m; cfg_dyn_gate = 1'b1;
        step();
        cfg_wr = 1'b0; cfg_mode = '0;
    endtask

    // external wake: applied now, acts at third edge
    task automatic ext_wake(input logic [2:0] from_state);
        ext_irq_async = 1'b1;
        step(); step();
        chk("R11 still low power after two edges", power_state, from_state);
        step();
        chk("R11 full after third edge", power_state, 0);
        chk("R12 ext wake pulse", wake_valid, 1);
        chk("R12 ext cause", wake_cause, 1);
        ext_irq_async = 1'b0;
        step();
        chk("R12 pulse one cycle", wake_valid, 0);
        chk("R12 cause cleared", wake_cause, 0);
        step(); step();
    endtask

    task automatic enter_deep(input logic [2:0] m, input logic [2:0] wait_st, input logic [2:0] fin);
        wr_mode(m);
        chk("R7 wait state", power_state, wait_st);
        chk("R7 coh_req high", coh_req, 1);
        chk("R7 clocks as full", unit_clk_en, unit_need | 5'b00001);
        step();
        chk("R7 holds without ack", power_state, wait_st);
        coh_ack = 1'b1;
        step();
        coh_ack = 1'b0;
        chk("R7 granted", power_state, fin);
        chk("R9 coh_req dropped", coh_req, 0);
        chk("R9 snoop off", snoop_en, 0);
    endtask

    initial begin
        logic [2:0] exp_st;
        #35;
        rst_n = 1'b1;
        #1;
        chk("R1 state", power_state, 0);
        chk("R1 clocks", unit_clk_en, 5'h1F);
        chk("R1 snoop", snoop_en, 1);
        chk("R1 coh_req", coh_req, 0);
        chk("R1 wake pulse", wake_valid, 1);
        chk("R1 wake cause", wake_cause, 3);
        step();
        chk("R1 pulse ends", wake_valid, 0);

        // gating disabled: all demand vectors give all ones
        for (int n = 0; n < 32; n++) begin
            unit_need = n[NU-1:0]; #1;
            chk("R2 gating off", unit_clk_en, 5'h1F);
        end
        // enable gating with an empty mode word (also an ignored request)
        wr_mode(3'b000);
        chk("R3 zero bits stays full", power_state, 0);
        for (int n = 0; n < 32; n++) begin
            unit_need = n[NU-1:0]; #1;
            chk("R2 gating on", unit_clk_en, n[NU-1:0] | 5'b00001);
        end
        unit_need = 5'b10100;

        // sweep all mode patterns
        for (int m = 0; m < 8; m++) begin
            wr_mode(m[2:0]);
            case (m)
                1: exp_st = 3'd1;
                2: exp_st = 3'd3;
                4: exp_st = 3'd4;
                default: exp_st = 3'd0;
            endcase
            chk("R3 mode decode", power_state, exp_st);
            if (exp_st == 3'd1) begin
                dec_irq = 1'b1; step(); dec_irq = 1'b0;
                chk("R12 dec wake state", power_state, 0);
                chk("R12 dec pulse", wake_valid, 1);
                chk("R12 dec cause", wake_cause, 2);
            end else if (exp_st != 3'd0) begin
                chk("R7 coh_req", coh_req, 1);
                dec_irq = 1'b1; step(); dec_irq = 1'b0;
                chk("R8 abort to full", power_state, 0);
                chk("R8 no pulse", wake_valid, 0);
            end
            step();
            chk("R12 no lingering pulse", wake_valid, 0);
        end

        // doze behaviour
        wr_mode(3'b001);
        chk("R5 doze state", power_state, 1);
        chk("R5 doze clocks", unit_clk_en, 5'b00001);
        chk("R5 doze snoop", snoop_en, 1);
        wr_mode(3'b100);
        chk("R4 request in doze ignored", power_state, 1);
        snoop_hit = 1'b1; step(); snoop_hit = 1'b0;
        chk("R6 copy-back state", power_state, 2);
        chk("R6 cache clocked", unit_clk_en, 5'b00011);
        step();
        chk("R6 waits for done", power_state, 2);
        copyback_done = 1'b1; step(); copyback_done = 1'b0;
        chk("R6 back to doze", power_state, 1);
        chk("R6 no wake pulse", wake_valid, 0);
        ext_wake(3'd1);

        // nap
        enter_deep(3'b010, 3'd3, 3'd5);
        chk("R9 nap clocks", unit_clk_en, 5'b00001);
        wr_mode(3'b001);
        chk("R4 request in nap ignored", power_state, 5);
        dec_irq = 1'b1; step(); dec_irq = 1'b0;
        chk("R9 dec wakes nap", power_state, 0);
        chk("R12 nap dec cause", wake_cause, 2);
        step();
        enter_deep(3'b010, 3'd3, 3'd5);
        ext_wake(3'd5);

        // priority: both sources at the same edge in nap
        enter_deep(3'b010, 3'd3, 3'd5);
        ext_irq_async = 1'b1; step(); step();
        dec_irq = 1'b1; step();
        dec_irq = 1'b0; ext_irq_async = 1'b0;
        chk("R12 priority state", power_state, 0);
        chk("R12 ext wins", wake_cause, 1);
        step(); step(); step();

        // sleep
        enter_deep(3'b100, 3'd4, 3'd6);
        chk("R10 no clocks", unit_clk_en, 5'b00000);
        dec_irq = 1'b1; step(); step(); dec_irq = 1'b0;
        chk("R10 dec ignored", power_state, 6);
        chk("R10 no pulse", wake_valid, 0);
        ext_wake(3'd6);

        // abort during sleep handshake via external interrupt
        wr_mode(3'b100);
        ext_irq_async = 1'b1; step(); step();
        ext_irq_async = 1'b0;
        chk("R8 not yet aborted", power_state, 4);
        step();
        chk("R8 ext abort", power_state, 0);
        chk("R8 ext abort no pulse", wake_valid, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule